// File: doc/BRIEF.md
# Power-Down Sequencer with Wakeup Arbitration

This block sequences a small microcontroller into and out of its low-power states. Software writes a 3-bit power level into a mode register. A non-zero level takes effect when the CPU signals that the writing instruction has retired. At that point the sequencer stops the CPU clock and, for the chosen level, turns off the crystal oscillator, switches the low-frequency clock to the internal low-power oscillator, or drops the main regulator.

While asleep the block watches three wake sources: port-0 GPIO events masked per pin, an RTC wake request and a watchdog reset. When one of them fires, the block clears the mode register and records which source won. GPIO wakes first wait out a debounce interval while still powered down. The block then counts a startup delay that depends on the sleep level, restores the CPU clock, and issues either a resume strobe (with an interrupt request when that source's interrupt is enabled) or a reset pulse for a watchdog wake.

Software reads back the current low-frequency clock level and the latched wake cause.

Top module: `pmu_ctrl`

## Requirements
- R1: After reset, cpuClkEn=1, xtalOscEn=1, lfSrcSel=0, mainRegEn=1, resumeStb, cpuRst, gpioIrq, rtcIrq and wrErr are 0, and regRdData[2:1]=00.
- R2: A write accepted while active takes effect as the mode register contents in the same cycle. The first cycle with instrDone=1 in which that contents is non-zero moves the block to a one-cycle gating step, so cpuClkEn is 0 from the next cycle on. A contents of 000 never starts power-down.
- R3: While asleep or debouncing, the outputs follow the latched level. Level 001 gives xtal on, crystal source, regulator on. Level 010 gives xtal on, crystal source, regulator off. Level 011 gives xtal on, low-power source (lfSrcSel=1), regulator off. Level 1xx gives xtal off, low-power source, regulator off. In every other state xtalOscEn=1, lfSrcSel=0 and mainRegEn=1.
- R4: cpuClkEn is 0 from the gating step until the startup delay ends, and 1 in every other state.
- R5: Wakes are taken only while asleep. A GPIO pin counts only when its gpioWakeEn bit is set, and the RTC counts only when rtcWakeEn=1. The watchdog always counts. When several fire together, the watchdog wins over the RTC, and the RTC wins over GPIO.
- R6: For an RTC or watchdog wake sampled at clock edge j, the resume strobe or reset pulse is high in the cycle after edge j+N. N is LIGHT_WAIT, MODERATE_WAIT, STANDBY_WAIT or DEEP_WAIT for levels 001, 010, 011 and 1xx.
- R7: A GPIO wake first spends DEBOUNCE_WAIT cycles with the sleep settings of R3 still applied, then runs the startup delay of R6.
- R8: A wake clears the mode register to 000, so a later instrDone does not re-enter power-down without a new write.
- R9: The end of a non-watchdog startup gives a one-cycle resumeStb. In that same cycle gpioIrq or rtcIrq is 1 if the winning source's interrupt enable (gpioIrqEn or rtcIrqEn) was 1 when the wake was taken.
- R10: A watchdog wake ends in a one-cycle cpuRst pulse with cpuClkEn=1, no resumeStb and no interrupt request.
- R11: A write while rtcBusy=1 is dropped, and wrErr is 1 in the following cycle.
- R12: regRdData bit 0 is the live lfClk level. Bits 2:1 hold the latched wake cause: 00 none, 01 GPIO, 10 RTC, 11 watchdog. Bits 7:3 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instrDone | input | 1 | CPU instruction-retired strobe |
| regWrEn | input | 1 | Mode register write strobe |
| regWrData | input | 3 | Mode register write value |
| regRdData | output | 8 | Read-back: cause and low-frequency clock level |
| rtcBusy | input | 1 | RTC/watchdog busy, blocks writes |
| wrErr | output | 1 | Write attempted while busy |
| lfClk | input | 1 | Low-frequency clock level |
| gpioEvt | input | GPIO_PINS | Port-0 pin events |
| gpioWakeEn | input | GPIO_PINS | Per-pin wake enables |
| rtcWake | input | 1 | RTC wake request |
| rtcWakeEn | input | 1 | RTC wake enable |
| wdtWake | input | 1 | Watchdog reset request |
| gpioIrqEn | input | 1 | GPIO interrupt enable |
| rtcIrqEn | input | 1 | RTC interrupt enable |
| cpuClkEn | output | 1 | CPU clock enable |
| xtalOscEn | output | 1 | Crystal oscillator enable |
| lfSrcSel | output | 1 | Low-frequency source: 1 = low-power oscillator |
| mainRegEn | output | 1 | Main regulator enable |
| resumeStb | output | 1 | Resume after power-down |
| cpuRst | output | 1 | CPU reset request |
| gpioIrq | output | 1 | GPIO interrupt request |
| rtcIrq | output | 1 | RTC interrupt request |

## Verification
The bench drives the case where a write and instrDone arrive in the same cycle. A design that sampled only the registered mode would stay awake for one instruction too long. It fires all three wake sources at once and checks that the watchdog wins: a wrong priority shows up as a resume in place of a reset, or as a debounce delay that should not be there. It counts the exact cycles from wake to resume for each level with and without debounce, so an off-by-one counter load or the wrong per-level wait is caught. It also tests a masked GPIO pin, a write while busy, and instrDone after a wake, each of which must leave the device awake or asleep exactly as before.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_GATING,
    ST_SLEEP,
    ST_DEBOUNCE,
    ST_STARTUP,
    ST_RESUME,
    ST_RESET
  } pmuState_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_GPIO = 2'd1,
    CAUSE_RTC  = 2'd2,
    CAUSE_WDT  = 2'd3
  } wakeCause_t;

  // strobes from control to datapath
  typedef struct packed {
    logic enterSleep;
    logic wakeLatch;
    logic loadDebounce;
    logic loadStartup;
    logic countDown;
  } pmuStrobe_t;

endpackage

// File: rtl/pmu_dpath.sv
module pmu_dpath
  import pmu_pkg::*;
#(
  parameter int GPIO_PINS     = 8,
  parameter int LIGHT_WAIT    = 3,
  parameter int MODERATE_WAIT = 7,
  parameter int STANDBY_WAIT  = 15,
  parameter int DEEP_WAIT     = 40,
  parameter int DEBOUNCE_WAIT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 regWrEn,
  input  logic [2:0]           regWrData,
  input  logic                 rtcBusy,
  input  logic                 isActive,
  input  logic                 sleeping,
  input  logic [GPIO_PINS-1:0] gpioEvt,
  input  logic [GPIO_PINS-1:0] gpioWakeEn,
  input  logic                 rtcWake,
  input  logic                 rtcWakeEn,
  input  logic                 wdtWake,
  input  logic                 gpioIrqEn,
  input  logic                 rtcIrqEn,
  input  logic                 lfClk,
  input  pmuStrobe_t           strb,
  output logic [2:0]           effMode,
  output logic [2:0]           modeQ,
  output logic                 wakeAny,
  output wakeCause_t           wakeNext,
  output wakeCause_t           causeQ,
  output logic                 irqPend,
  output logic                 cntZero,
  output logic                 wrErr,
  output logic                 xtalOscEn,
  output logic                 lfSrcSel,
  output logic                 mainRegEn,
  output logic [7:0]           regRdData
);

  localparam int MAX_A = (LIGHT_WAIT > MODERATE_WAIT) ? LIGHT_WAIT : MODERATE_WAIT;
  localparam int MAX_B = (STANDBY_WAIT > DEEP_WAIT) ? STANDBY_WAIT : DEEP_WAIT;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_W = (MAX_C > DEBOUNCE_WAIT) ? MAX_C : DEBOUNCE_WAIT;
  localparam int CNT_W = $clog2(MAX_W + 1);

  logic [2:0]       savedMode;
  logic [CNT_W-1:0] cnt;
  logic             acceptWr;
  logic             gpioHit;

  function automatic logic [CNT_W-1:0] waitFor(input logic [2:0] lvl);
    logic [CNT_W-1:0] w;
    if (lvl[2])              w = CNT_W'(DEEP_WAIT - 1);
    else if (lvl == 3'd3)    w = CNT_W'(STANDBY_WAIT - 1);
    else if (lvl == 3'd2)    w = CNT_W'(MODERATE_WAIT - 1);
    else                     w = CNT_W'(LIGHT_WAIT - 1);
    return w;
  endfunction

  // mode register write path
  assign acceptWr = regWrEn && !rtcBusy && isActive;
  assign effMode  = acceptWr ? regWrData : modeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= 3'd0;
      wrErr <= 1'b0;
    end else begin
      wrErr <= regWrEn && rtcBusy;
      if (strb.wakeLatch)  modeQ <= 3'd0;
      else if (acceptWr)   modeQ <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               savedMode <= 3'd0;
    else if (strb.enterSleep) savedMode <= effMode;
  end

  // wake arbitration: watchdog over RTC over GPIO
  assign gpioHit = |(gpioEvt & gpioWakeEn);

  always_comb begin
    if (wdtWake)                  wakeNext = CAUSE_WDT;
    else if (rtcWake && rtcWakeEn) wakeNext = CAUSE_RTC;
    else if (gpioHit)             wakeNext = CAUSE_GPIO;
    else                          wakeNext = CAUSE_NONE;
  end
  assign wakeAny = (wakeNext != CAUSE_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      causeQ  <= CAUSE_NONE;
      irqPend <= 1'b0;
    end else if (strb.wakeLatch) begin
      causeQ  <= wakeNext;
      irqPend <= ((wakeNext == CAUSE_GPIO) && gpioIrqEn) ||
                 ((wakeNext == CAUSE_RTC) && rtcIrqEn);
    end
  end

  // shared debounce / startup countdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (strb.loadDebounce) cnt <= CNT_W'(DEBOUNCE_WAIT - 1);
    else if (strb.loadStartup)  cnt <= waitFor(savedMode);
    else if (strb.countDown)    cnt <= cnt - 1'b1;
  end
  assign cntZero = (cnt == '0);

  // power domain outputs from the latched level
  assign xtalOscEn = !(sleeping && savedMode[2]);
  assign lfSrcSel  = sleeping && (savedMode[2] || (savedMode == 3'd3));
  assign mainRegEn = !(sleeping && (savedMode[2:1] != 2'b00));

  assign regRdData = {5'b0, causeQ, lfClk};

  // R11
  write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && rtcBusy && !strb.wakeLatch) |=> (modeQ == $past(modeQ)));

endmodule

// File: rtl/pmu_fsm.sv
module pmu_fsm
  import pmu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instrDone,
  input  logic [2:0] effMode,
  input  logic [2:0] modeQ,
  input  logic       wakeAny,
  input  wakeCause_t wakeNext,
  input  wakeCause_t causeQ,
  input  logic       cntZero,
  output pmuStrobe_t strb,
  output logic       isActive,
  output logic       sleeping,
  output logic       cpuClkEn,
  output logic       resumeStb,
  output logic       cpuRst
);

  pmuState_t state, nxt;

  always_comb begin
    nxt  = state;
    strb = '0;
    unique case (state)
      ST_ACTIVE: begin
        if (instrDone && (effMode != 3'd0)) begin
          strb.enterSleep = 1'b1;
          nxt = ST_GATING;
        end
      end
      ST_GATING: nxt = ST_SLEEP;
      ST_SLEEP: begin
        if (wakeAny) begin
          strb.wakeLatch = 1'b1;
          if (wakeNext == CAUSE_GPIO) begin
            strb.loadDebounce = 1'b1;
            nxt = ST_DEBOUNCE;
          end else begin
            strb.loadStartup = 1'b1;
            nxt = ST_STARTUP;
          end
        end
      end
      ST_DEBOUNCE: begin
        if (cntZero) begin
          strb.loadStartup = 1'b1;
          nxt = ST_STARTUP;
        end else begin
          strb.countDown = 1'b1;
        end
      end
      ST_STARTUP: begin
        if (cntZero) nxt = (causeQ == CAUSE_WDT) ? ST_RESET : ST_RESUME;
        else         strb.countDown = 1'b1;
      end
      ST_RESUME: nxt = ST_ACTIVE;
      ST_RESET:  nxt = ST_ACTIVE;
      default:   nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ACTIVE;
    else        state <= nxt;
  end

  assign isActive  = (state == ST_ACTIVE);
  assign sleeping  = (state == ST_SLEEP) || (state == ST_DEBOUNCE);
  assign cpuClkEn  = (state == ST_ACTIVE) || (state == ST_RESUME) || (state == ST_RESET);
  assign resumeStb = (state == ST_RESUME);
  assign cpuRst    = (state == ST_RESET);

  // R2
  gating_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ACTIVE) && instrDone && (effMode != 3'd0)) |=> !cpuClkEn);

  // R10
  wdt_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpuRst |-> (causeQ == CAUSE_WDT));

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STARTUP) |-> (modeQ == 3'd0));

  // R7
  debounce_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEBOUNCE) |-> (causeQ == CAUSE_GPIO));

endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int GPIO_PINS     = 8,
  parameter int LIGHT_WAIT    = 3,
  parameter int MODERATE_WAIT = 7,
  parameter int STANDBY_WAIT  = 15,
  parameter int DEEP_WAIT     = 40,
  parameter int DEBOUNCE_WAIT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instrDone,
  input  logic                 regWrEn,
  input  logic [2:0]           regWrData,
  output logic [7:0]           regRdData,
  input  logic                 rtcBusy,
  output logic                 wrErr,
  input  logic                 lfClk,
  input  logic [GPIO_PINS-1:0] gpioEvt,
  input  logic [GPIO_PINS-1:0] gpioWakeEn,
  input  logic                 rtcWake,
  input  logic                 rtcWakeEn,
  input  logic                 wdtWake,
  input  logic                 gpioIrqEn,
  input  logic                 rtcIrqEn,
  output logic                 cpuClkEn,
  output logic                 xtalOscEn,
  output logic                 lfSrcSel,
  output logic                 mainRegEn,
  output logic                 resumeStb,
  output logic                 cpuRst,
  output logic                 gpioIrq,
  output logic                 rtcIrq
);

  pmuStrobe_t strb;
  logic [2:0] effMode, modeQ;
  logic       wakeAny, irqPend, cntZero, isActive, sleeping;
  wakeCause_t wakeNext, causeQ;

  pmu_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .instrDone(instrDone),
    .effMode(effMode), .modeQ(modeQ), .wakeAny(wakeAny),
    .wakeNext(wakeNext), .causeQ(causeQ), .cntZero(cntZero),
    .strb(strb), .isActive(isActive), .sleeping(sleeping),
    .cpuClkEn(cpuClkEn), .resumeStb(resumeStb), .cpuRst(cpuRst)
  );

  pmu_dpath #(
    .GPIO_PINS(GPIO_PINS), .LIGHT_WAIT(LIGHT_WAIT),
    .MODERATE_WAIT(MODERATE_WAIT), .STANDBY_WAIT(STANDBY_WAIT),
    .DEEP_WAIT(DEEP_WAIT), .DEBOUNCE_WAIT(DEBOUNCE_WAIT)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .rtcBusy(rtcBusy), .isActive(isActive), .sleeping(sleeping),
    .gpioEvt(gpioEvt), .gpioWakeEn(gpioWakeEn), .rtcWake(rtcWake),
    .rtcWakeEn(rtcWakeEn), .wdtWake(wdtWake), .gpioIrqEn(gpioIrqEn),
    .rtcIrqEn(rtcIrqEn), .lfClk(lfClk), .strb(strb),
    .effMode(effMode), .modeQ(modeQ), .wakeAny(wakeAny),
    .wakeNext(wakeNext), .causeQ(causeQ), .irqPend(irqPend),
    .cntZero(cntZero), .wrErr(wrErr), .xtalOscEn(xtalOscEn),
    .lfSrcSel(lfSrcSel), .mainRegEn(mainRegEn), .regRdData(regRdData)
  );

  assign gpioIrq = resumeStb && irqPend && (causeQ == CAUSE_GPIO);
  assign rtcIrq  = resumeStb && irqPend && (causeQ == CAUSE_RTC);

  // R9
  irq_with_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpioIrq || rtcIrq) |-> (cpuClkEn && !cpuRst));

endmodule

// File: tb/pmu_ctrl_bench.sv
module pmu_ctrl_bench;

  localparam int PINS = 8;
  localparam int LW = 3, MW = 7, SW = 15, DW = 40, BW = 4;

  logic clk = 0, rst_n = 0;
  logic instrDone = 0, regWrEn = 0, rtcBusy = 0, lfClk = 0;
  logic [2:0] regWrData = 0;
  logic [PINS-1:0] gpioEvt = 0, gpioWakeEn = 0;
  logic rtcWake = 0, rtcWakeEn = 0, wdtWake = 0, gpioIrqEn = 0, rtcIrqEn = 0;
  logic [7:0] regRdData;
  logic wrErr, cpuClkEn, xtalOscEn, lfSrcSel, mainRegEn, resumeStb, cpuRst, gpioIrq, rtcIrq;

  int vectors = 0, errors = 0;
  bit finished = 0;

  pmu_ctrl #(.GPIO_PINS(PINS), .LIGHT_WAIT(LW), .MODERATE_WAIT(MW),
             .STANDBY_WAIT(SW), .DEEP_WAIT(DW), .DEBOUNCE_WAIT(BW)) u_pmu_ctrl (
    .clk(clk), .rst_n(rst_n), .instrDone(instrDone), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .rtcBusy(rtcBusy), .wrErr(wrErr),
    .lfClk(lfClk), .gpioEvt(gpioEvt), .gpioWakeEn(gpioWakeEn), .rtcWake(rtcWake),
    .rtcWakeEn(rtcWakeEn), .wdtWake(wdtWake), .gpioIrqEn(gpioIrqEn), .rtcIrqEn(rtcIrqEn),
    .cpuClkEn(cpuClkEn), .xtalOscEn(xtalOscEn), .lfSrcSel(lfSrcSel), .mainRegEn(mainRegEn),
    .resumeStb(resumeStb), .cpuRst(cpuRst), .gpioIrq(gpioIrq), .rtcIrq(rtcIrq)
  );

  always #5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  // phases: 0 awake, 1 gate, 2 asleep, 3 debounce, 4 warmup, 5 resume, 6 reset
  int mPh = 0, mCnt = 0, mMode = 0, mLvl = 0, mCause = 0;
  bit mIrq = 0, mErr = 0;

  function automatic int levelWait(int lvl);
    if (lvl >= 4) return DW;
    if (lvl == 3) return SW;
    if (lvl == 2) return MW;
    return LW;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mPh = 0; mCnt = 0; mMode = 0; mLvl = 0; mCause = 0; mIrq = 0; mErr = 0;
    end else begin
      bit ok;
      int eff, win;
      ok  = regWrEn && !rtcBusy && (mPh == 0);
      eff = ok ? int'(regWrData) : mMode;
      mErr = regWrEn && rtcBusy;
      case (mPh)
        0: begin
          if (ok) mMode = regWrData;
          if (instrDone && eff != 0) begin mLvl = eff; mPh = 1; end
        end
        1: mPh = 2;
        2: begin
          win = 0;
          if (|(gpioEvt & gpioWakeEn)) win = 1;
          if (rtcWake && rtcWakeEn) win = 2;
          if (wdtWake) win = 3;
          if (win != 0) begin
            mMode = 0; mCause = win;
            mIrq = (win == 1 && gpioIrqEn) || (win == 2 && rtcIrqEn);
            if (win == 1) begin mPh = 3; mCnt = BW; end
            else begin mPh = 4; mCnt = levelWait(mLvl); end
          end
        end
        3: begin mCnt--; if (mCnt == 0) begin mPh = 4; mCnt = levelWait(mLvl); end end
        4: begin mCnt--; if (mCnt == 0) mPh = (mCause == 3) ? 6 : 5; end
        default: mPh = 0;
      endcase
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit slp;
      slp = (mPh == 2) || (mPh == 3);
      cmp("R4 cpuClkEn", cpuClkEn, (mPh == 0 || mPh == 5 || mPh == 6));
      cmp("R3 xtalOscEn", xtalOscEn, !(slp && mLvl >= 4));
      cmp("R3 lfSrcSel", lfSrcSel, slp && mLvl >= 3);
      cmp("R3 mainRegEn", mainRegEn, !(slp && mLvl >= 2));
      cmp("R9 resumeStb", resumeStb, mPh == 5);
      cmp("R10 cpuRst", cpuRst, mPh == 6);
      cmp("R9 gpioIrq", gpioIrq, mPh == 5 && mIrq && mCause == 1);
      cmp("R9 rtcIrq", rtcIrq, mPh == 5 && mIrq && mCause == 2);
      cmp("R11 wrErr", wrErr, mErr);
      cmp("R12 regRdData", regRdData, (mCause << 1) | int'(lfClk));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  int tick = 0;
  always @(negedge clk) begin
    #1 tick++;
    if (tick % 3 == 0) lfClk = ~lfClk;
  end

  task automatic sleepAt(input int lvl);
    regWrEn = 1; regWrData = 3'(lvl); instrDone = 1;
    step();
    regWrEn = 0; instrDone = 0;
    step();
  endtask

  // returns steps from wake until resume or reset is visible
  task automatic waitEnd(output int n, input bit chkDeb);
    n = 0;
    do begin
      step(); n++;
      gpioEvt = 0; rtcWake = 0; wdtWake = 0;
      if (chkDeb && n == BW) cmp("R7 sleep settings kept in debounce", mainRegEn, 0);
    end while (!resumeStb && !cpuRst && n < 500);
  endtask

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1;
    step();
    cmp("R1 cpuClkEn", cpuClkEn, 1);
    cmp("R1 xtalOscEn", xtalOscEn, 1);
    cmp("R1 lfSrcSel", lfSrcSel, 0);
    cmp("R1 mainRegEn", mainRegEn, 1);
    cmp("R1 cause", regRdData[2:1], 0);

    // level 001, write and instrDone together, RTC wake with interrupt
    rtcWakeEn = 1; rtcIrqEn = 1;
    regWrEn = 1; regWrData = 3'd1; instrDone = 1;
    step();
    regWrEn = 0; instrDone = 0;
    cmp("R2 clock gated after same-cycle write", cpuClkEn, 0);
    step();
    cmp("R3 light keeps xtal", xtalOscEn, 1);
    rtcWake = 1;
    waitEnd(n, 0);
    cmp("R6 light startup cycles", n, LW + 1);
    cmp("R9 rtc irq", rtcIrq, 1);
    step();
    cmp("R12 cause rtc", regRdData[2:1], 2);
    instrDone = 1; step(); instrDone = 0; step();
    cmp("R8 no re-entry after wake", cpuClkEn, 1);

    // level 010, delayed trigger, masked then enabled GPIO
    gpioWakeEn = 8'h01; gpioIrqEn = 1;
    regWrEn = 1; regWrData = 3'd2; step(); regWrEn = 0;
    step();
    cmp("R2 waits for instrDone", cpuClkEn, 1);
    instrDone = 1; step(); instrDone = 0; step();
    cmp("R3 moderate regulator off", mainRegEn, 0);
    gpioEvt = 8'h02; step(); gpioEvt = 0; step();
    cmp("R5 masked pin ignored", cpuClkEn, 0);
    gpioEvt = 8'h01;
    waitEnd(n, 1);
    cmp("R7 debounce plus startup", n, BW + MW + 1);
    cmp("R9 gpio irq", gpioIrq, 1);
    step();

    // level 011, all sources together -> watchdog
    gpioWakeEn = 8'hFF;
    sleepAt(3);
    cmp("R3 standby low-power source", lfSrcSel, 1);
    wdtWake = 1; rtcWake = 1; gpioEvt = 8'hFF;
    waitEnd(n, 0);
    cmp("R10 reset on watchdog", cpuRst, 1);
    cmp("R10 no resume", resumeStb, 0);
    cmp("R5 watchdog priority timing", n, SW + 1);
    step();
    cmp("R12 cause wdt", regRdData[2:1], 3);

    // level 110 (deep), RTC beats GPIO, RTC interrupt disabled
    rtcIrqEn = 0;
    sleepAt(6);
    cmp("R3 deep xtal off", xtalOscEn, 0);
    rtcWake = 1; gpioEvt = 8'h10;
    waitEnd(n, 0);
    cmp("R5 rtc over gpio", n, DW + 1);
    cmp("R9 irq suppressed", rtcIrq, 0);
    step();

    // busy blocks the write
    rtcBusy = 1; regWrEn = 1; regWrData = 3'd2; step();
    rtcBusy = 0; regWrEn = 0;
    cmp("R11 wrErr", wrErr, 1);
    instrDone = 1; step(); instrDone = 0; step();
    cmp("R11 blocked write has no effect", cpuClkEn, 1);

    // zero level never sleeps
    regWrEn = 1; regWrData = 3'd0; instrDone = 1; step();
    regWrEn = 0; instrDone = 0; step();
    cmp("R2 zero level stays awake", cpuClkEn, 1);

    // wake sources while awake
    wdtWake = 1; rtcWake = 1; step(); wdtWake = 0; rtcWake = 0; step();
    cmp("R5 wake ignored while awake", cpuRst, 0);

    repeat (3) step();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule